// File: doc/BRIEF.md
# Sigma-Delta Result Formatter

This block is the last arithmetic step behind a sigma-delta decimation filter and integrator. Each finished conversion arrives as a signed 32-bit intermediate value, together with the configuration of the channel that produced it: a 5-bit right-shift count and a 24-bit signed offset. The block divides the value by a power of two with round-to-nearest and clamps it to 24-bit signed range. It then subtracts the offset, again with clamping, and packs the result into the upper 24 bits of a 32-bit data word. The low byte of that word carries the source channel index.

Two result paths exist, regular and injected. They share the arithmetic but each has its own data word and its own end-of-conversion flag. A conversion strobe loads the selected word and raises its flag on the same clock edge. A read strobe for a path clears that path's flag. Dropping the block enable aborts the flow: both flags clear, strobes are ignored, and the stored data words keep their values.

Top module: `sdm_result_stage`

## Requirements
- R1: After reset both data words read 0 and both end-of-conversion flags are 0.
- R2: With a shift count of 0 the input value passes unshifted into the offset stage.
- R3: With a shift count s from 1 to 31 the value becomes floor((x + 2^(s-1)) / 2^s), computed without overflow (so 5>>1 gives 3 and -3>>1 gives -1).
- R4: The shifted value is clamped to the range -2^23 to 2^23-1 and never wraps.
- R5: The signed 24-bit offset is subtracted from the clamped value, and the difference is clamped to the same 24-bit signed range.
- R6: In each data word, bits 31:8 hold the 24-bit two's complement result, bits 7:3 are zero and bits 2:0 hold the channel index.
- R7: When enabled, a conversion strobe with the path select at 0 (regular) or 1 (injected) loads only that path's word and sets only that path's flag at the next clock edge. The other path's word and flag are left unchanged.
- R8: A read strobe for a path clears that path's flag at the next edge. If a new conversion for the same path arrives in the same cycle, the flag stays set.
- R9: While the enable is low both flags are forced to 0, conversion strobes are ignored, and both data words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and clears flags |
| conv_valid | input | 1 | A finished conversion is present this cycle |
| conv_inj | input | 1 | Path select for the conversion: 0 regular, 1 injected |
| conv_data | input | 32 | Signed intermediate result |
| conv_chan | input | 3 | Source channel index |
| cfg_shift | input | 5 | Right-shift count of the source channel |
| cfg_offset | input | 24 | Signed offset of the source channel |
| rd_reg | input | 1 | Read strobe of the regular data word |
| rd_inj | input | 1 | Read strobe of the injected data word |
| reg_word | output | 32 | Regular data word |
| inj_word | output | 32 | Injected data word |
| reg_eoc | output | 1 | Regular end-of-conversion flag |
| inj_eoc | output | 1 | Injected end-of-conversion flag |

## Verification
The arithmetic is first tried with directed values chosen to separate its behaviours. Odd values at shift 1 and 2 tell round-to-nearest apart from truncation, and negative values reveal a logical shift used where an arithmetic one is needed. Extreme inputs at shift 0, 4 and 31 show whether clamping happens or the value wraps. Offsets that push the difference past either end of the 24-bit range do the same for the subtraction stage, and channel 7 with a zero result isolates the low-byte layout. A long run of random values, shifts, offsets, channels, path selects, reads and enable drops is then compared every cycle against a behavioural model. That run separates the two paths, the set-versus-clear priority, and the retention of data while disabled.

// File: rtl/sdm_out_pkg.sv
package sdm_out_pkg;
    localparam int unsigned IN_W   = 32;
    localparam int unsigned OUT_W  = 24;
    localparam int unsigned SH_W   = 5;
    localparam int unsigned CH_W   = 3;
    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        PATH_REG = 1'b0,
        PATH_INJ = 1'b1
    } path_e;
endpackage

// File: rtl/sdm_round_shift.sv
module sdm_round_shift #(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned OUT_W = 24,
    parameter int unsigned SH_W  = 5
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [SH_W-1:0]  sh,
    output logic signed [OUT_W-1:0] dout
);
    localparam int unsigned EW = IN_W + 1;
    localparam logic signed [EW-1:0] HI = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = {{(EW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [EW-1:0] ext_d;
    logic signed [EW-1:0] half_d;
    logic signed [EW-1:0] sum_d;
    logic signed [EW-1:0] shd_d;

    always_comb begin
        ext_d  = {din[IN_W-1], din};
        half_d = '0;
        if (sh != '0) begin
            half_d = {{(EW-1){1'b0}}, 1'b1} << (sh - 1'b1);
        end
        sum_d = ext_d + half_d;
        shd_d = sum_d >>> sh;
        if (shd_d > HI) begin
            dout = HI[OUT_W-1:0];
        end else if (shd_d < LO) begin
            dout = LO[OUT_W-1:0];
        end else begin
            dout = shd_d[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/sdm_offset_sub.sv
module sdm_offset_sub #(
    parameter int unsigned OUT_W = 24
) (
    input  logic signed [OUT_W-1:0] din,
    input  logic signed [OUT_W-1:0] off,
    output logic signed [OUT_W-1:0] dout
);
    logic signed [OUT_W:0] diff_d;

    always_comb begin
        diff_d = {din[OUT_W-1], din} - {off[OUT_W-1], off};
        if (diff_d[OUT_W] != diff_d[OUT_W-1]) begin
            dout = diff_d[OUT_W] ? {1'b1, {(OUT_W-1){1'b0}}}
                                 : {1'b0, {(OUT_W-1){1'b1}}};
        end else begin
            dout = diff_d[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/sdm_result_stage.sv
module sdm_result_stage
    import sdm_out_pkg::*;
#(
    parameter int unsigned P_IN_W   = IN_W,
    parameter int unsigned P_OUT_W  = OUT_W,
    parameter int unsigned P_SH_W   = SH_W,
    parameter int unsigned P_CH_W   = CH_W,
    parameter int unsigned P_WORD_W = WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     conv_valid,
    input  logic                     conv_inj,
    input  logic signed [P_IN_W-1:0] conv_data,
    input  logic [P_CH_W-1:0]        conv_chan,
    input  logic [P_SH_W-1:0]        cfg_shift,
    input  logic [P_OUT_W-1:0]       cfg_offset,
    input  logic                     rd_reg,
    input  logic                     rd_inj,
    output logic [P_WORD_W-1:0]      reg_word,
    output logic [P_WORD_W-1:0]      inj_word,
    output logic                     reg_eoc,
    output logic                     inj_eoc
);
    localparam int unsigned PAD_W = P_WORD_W - P_OUT_W - P_CH_W;

    typedef struct packed {
        logic [P_WORD_W-1:0] rword;
        logic [P_WORD_W-1:0] iword;
        logic                reoc;
        logic                ieoc;
    } state_t;

    state_t st_q, st_d;

    logic signed [P_OUT_W-1:0] shifted_d;
    logic signed [P_OUT_W-1:0] final_d;
    logic [P_WORD_W-1:0]       packed_d;
    path_e                     path_d;

    sdm_round_shift #(
        .IN_W  (P_IN_W),
        .OUT_W (P_OUT_W),
        .SH_W  (P_SH_W)
    ) u_shift (
        .din  (conv_data),
        .sh   (cfg_shift),
        .dout (shifted_d)
    );

    sdm_offset_sub #(
        .OUT_W (P_OUT_W)
    ) u_sub (
        .din  (shifted_d),
        .off  (cfg_offset),
        .dout (final_d)
    );

    always_comb begin
        packed_d = {final_d, {PAD_W{1'b0}}, conv_chan};
        path_d   = path_e'(conv_inj);
        st_d     = st_q;
        if (!enable) begin
            st_d.reoc = 1'b0;
            st_d.ieoc = 1'b0;
        end else begin
            if (rd_reg) st_d.reoc = 1'b0;
            if (rd_inj) st_d.ieoc = 1'b0;
            if (conv_valid) begin
                if (path_d == PATH_INJ) begin
                    st_d.iword = packed_d;
                    st_d.ieoc  = 1'b1;
                end else begin
                    st_d.rword = packed_d;
                    st_d.reoc  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_word = st_q.rword;
    assign inj_word = st_q.iword;
    assign reg_eoc  = st_q.reoc;
    assign inj_eoc  = st_q.ieoc;

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!reg_eoc && !inj_eoc));
    a_r9_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(reg_word) && $stable(inj_word)));
    a_r7_reg_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conv_valid && !conv_inj) |=> (reg_eoc && $stable(inj_word)));
    a_r7_inj_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conv_valid && conv_inj) |=> (inj_eoc && $stable(reg_word)));
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rd_reg && !(conv_valid && !conv_inj)) |=> !reg_eoc);
    a_r8_inj_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rd_inj && !(conv_valid && conv_inj)) |=> !inj_eoc);
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word[P_CH_W +: PAD_W] == '0) && (inj_word[P_CH_W +: PAD_W] == '0));
endmodule

// File: tb/sdm_result_stage_bench.sv
module sdm_result_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        conv_valid = 1'b0;
    logic        conv_inj = 1'b0;
    logic [31:0] conv_data = '0;
    logic [2:0]  conv_chan = '0;
    logic [4:0]  cfg_shift = '0;
    logic [23:0] cfg_offset = '0;
    logic        rd_reg = 1'b0;
    logic        rd_inj = 1'b0;
    logic [31:0] reg_word, inj_word;
    logic        reg_eoc, inj_eoc;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_rw = '0, m_iw = '0;
    logic        m_re = 1'b0, m_ie = 1'b0;

    always #10 clk = ~clk;

    sdm_result_stage u_sdm_result_stage (
        .clk, .rst_n, .enable, .conv_valid, .conv_inj,
        .conv_data(signed'(conv_data)), .conv_chan, .cfg_shift, .cfg_offset,
        .rd_reg, .rd_inj, .reg_word, .inj_word, .reg_eoc, .inj_eoc
    );

    function automatic logic [31:0] ref_word(logic [31:0] x, int s, logic [23:0] off, int ch);
        longint v;
        longint o;
        v = longint'($signed(x));
        if (s > 0) v = (v + (longint'(1) <<< (s - 1))) >>> s;
        if (v > 8388607) v = 8388607;
        if (v < -8388608) v = -8388608;
        o = longint'($signed(off));
        v = v - o;
        if (v > 8388607) v = 8388607;
        if (v < -8388608) v = -8388608;
        return {v[23:0], 5'b00000, ch[2:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rw = '0; m_iw = '0; m_re = 1'b0; m_ie = 1'b0;
        end else if (!enable) begin
            m_re = 1'b0; m_ie = 1'b0;
        end else begin
            if (rd_reg) m_re = 1'b0;
            if (rd_inj) m_ie = 1'b0;
            if (conv_valid) begin
                if (conv_inj) begin
                    m_iw = ref_word(conv_data, int'(cfg_shift), cfg_offset, int'(conv_chan));
                    m_ie = 1'b1;
                end else begin
                    m_rw = ref_word(conv_data, int'(cfg_shift), cfg_offset, int'(conv_chan));
                    m_re = 1'b1;
                end
            end
        end
        started = 1'b1;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "reg_word model", reg_word, m_rw);
            chk(cur_req, "inj_word model", inj_word, m_iw);
            chk(cur_req, "reg_eoc model", {31'b0, reg_eoc}, {31'b0, m_re});
            chk(cur_req, "inj_eoc model", {31'b0, inj_eoc}, {31'b0, m_ie});
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    task automatic direct(string req, logic [31:0] x, logic [4:0] s, logic [23:0] off,
                          logic [2:0] ch, logic inj, logic [31:0] exp);
        @(negedge clk);
        conv_valid = 1'b1; conv_inj = inj; conv_data = x;
        cfg_shift = s; cfg_offset = off; conv_chan = ch;
        @(negedge clk);
        conv_valid = 1'b0;
        chk(req, "directed word", inj ? inj_word : reg_word, exp);
        chk(req, "directed flag", {31'b0, inj ? inj_eoc : reg_eoc}, 32'd1);
    endtask

    initial begin
        logic [31:0] held_r, held_i;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset reg_word", reg_word, 32'h0);
        chk("R1", "reset inj_word", inj_word, 32'h0);
        chk("R1", "reset flags", {30'b0, reg_eoc, inj_eoc}, 32'h0);
        rst_n = 1'b1;
        enable = 1'b1;

        cur_req = "R2";
        direct("R2", 32'h00001234, 5'd0, 24'h0, 3'd5, 1'b0, 32'h00123405);
        cur_req = "R3";
        direct("R3", 32'd5, 5'd1, 24'h0, 3'd1, 1'b0, 32'h00000301);
        direct("R3", 32'hFFFFFFFD, 5'd1, 24'h0, 3'd2, 1'b1, 32'hFFFFFF02);
        direct("R3", 32'hFFFFFFFB, 5'd2, 24'h0, 3'd0, 1'b0, 32'hFFFFFF00);
        direct("R3", 32'd6, 5'd2, 24'h0, 3'd0, 1'b1, 32'h00000200);
        direct("R3", 32'h80000000, 5'd31, 24'h0, 3'd0, 1'b0, 32'hFFFFFF00);
        cur_req = "R4";
        direct("R4", 32'h7FFFFFFF, 5'd0, 24'h0, 3'd0, 1'b0, 32'h7FFFFF00);
        direct("R4", 32'h80000000, 5'd4, 24'h0, 3'd0, 1'b1, 32'h80000000);
        direct("R4", 32'h7FFFFFFF, 5'd31, 24'h0, 3'd0, 1'b0, 32'h00000100);
        cur_req = "R5";
        direct("R5", 32'd100, 5'd0, 24'd30, 3'd0, 1'b0, 32'h00004600);
        direct("R5", 32'hFF800000, 5'd0, 24'd1, 3'd0, 1'b1, 32'h80000000);
        direct("R5", 32'h007FFFFF, 5'd0, 24'hFFFFFF, 3'd0, 1'b0, 32'h7FFFFF00);
        cur_req = "R6";
        direct("R6", 32'h0, 5'd0, 24'h0, 3'd7, 1'b1, 32'h00000007);

        cur_req = "R7";
        @(negedge clk); rd_reg = 1'b1; rd_inj = 1'b1;
        @(negedge clk); rd_reg = 1'b0; rd_inj = 1'b0;
        held_i = inj_word;
        direct("R7", 32'h00000400, 5'd2, 24'h0, 3'd3, 1'b0, 32'h00010003);
        chk("R7", "other path word", inj_word, held_i);
        chk("R7", "other path flag", {31'b0, inj_eoc}, 32'd0);

        cur_req = "R8";
        @(negedge clk); rd_reg = 1'b1;
        @(negedge clk); rd_reg = 1'b0;
        chk("R8", "read clears flag", {31'b0, reg_eoc}, 32'd0);
        @(negedge clk); rd_reg = 1'b1; conv_valid = 1'b1; conv_inj = 1'b0;
        @(negedge clk); rd_reg = 1'b0; conv_valid = 1'b0;
        chk("R8", "set beats read", {31'b0, reg_eoc}, 32'd1);

        cur_req = "R9";
        held_r = reg_word; held_i = inj_word;
        @(negedge clk); enable = 1'b0; conv_valid = 1'b1; conv_data = 32'h00ABCDEF;
        @(negedge clk);
        chk("R9", "flags cleared", {30'b0, reg_eoc, inj_eoc}, 32'd0);
        chk("R9", "reg word held", reg_word, held_r);
        chk("R9", "inj word held", inj_word, held_i);
        conv_valid = 1'b0; enable = 1'b1;

        cur_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            conv_valid = ($urandom_range(0, 3) != 0);
            conv_inj   = $urandom_range(0, 1) == 1;
            conv_data  = $urandom;
            cfg_shift  = 5'($urandom_range(0, 31));
            cfg_offset = 24'($urandom);
            conv_chan  = 3'($urandom_range(0, 7));
            rd_reg     = $urandom_range(0, 2) == 0;
            rd_inj     = $urandom_range(0, 2) == 0;
            enable     = $urandom_range(0, 15) != 0;
        end
        @(negedge clk);
        conv_valid = 1'b0; rd_reg = 1'b0; rd_inj = 1'b0; enable = 1'b1;
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule